// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects interrupt events from peripheral sources into a sticky 16-bit pending register. It gates that register with a 16-bit enable register and drives one level-sensitive request line to the CPU. Each source reports an event with a single-cycle pulse, and the matching pending bit then stays set until software clears it. A separate pulse input serves the DMA controller and lands on pending bit 3.

Software reaches both registers over a plain register bus. The bus has a byte offset, a write strobe and 32-bit write and read data. Reads are combinational from the offset, and writes take effect at the next clock edge. Software clears pending bits by writing an AND mask to the pending register: a 0 clears the bit and a 1 keeps it. A write to the enable register replaces its contents. When such a write newly enables a bit that is already pending, the block raises a one-cycle notification pulse. The bus carries no data stream, so every pin is a plain control or status signal and none has a handshake.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset, the pending register reads 0x0000, the enable register reads 0x0000, and both `irq` and `unmask_evt` are 0.
- R2: A 1 on bit i of `src_set` in a cycle sets pending bit i at the next edge. The bit then stays set through cycles that have neither a pulse nor a write to the pending register.
- R3: A write to offset 0x70 (the pending register) makes the new pending value equal to the old value ANDed with `bus_wdata[15:0]`.
- R4: When a set pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x74 (the enable register) replaces the enable register with `bus_wdata[15:0]`.
- R6: `irq` is registered and equals the OR of (pending AND enable). It changes at the same clock edge as the register update that causes the change, which is one cycle after the bus write or pulse.
- R7: `unmask_evt` is high for exactly the cycle after an enable write when (written low half AND NOT old enable AND old pending) is nonzero. Otherwise it is low.
- R8: Reads at offsets 0x70 and 0x74 return the register in bits [15:0] and zero in bits [31:16]. Any other offset reads 0. A write to any other offset changes no register.
- R9: A pulse on `dma_set` sets pending bit 3 in the same way as `src_set[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data; only bits [15:0] are used |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_set | input | 16 | Per-source set pulses |
| dma_set | input | 1 | DMA controller set pulse, maps to bit 3 |
| irq | output | 1 | Registered level request to the CPU |
| unmask_evt | output | 1 | One-cycle pulse when an enable write exposes a pending bit |

## Verification
The bench drives a clearing write to the pending register in the same cycle as a set pulse on the same bit. A design where the clear won would lose that event. It then writes the enable register twice with the same value over a pending bit. A design that fires `unmask_evt` on every enable write with pending bits set would pulse on the second write, where only the first should pulse. Writes to an unmapped offset with all ones check that neither register is disturbed, and upper-half write data checks that reads stay zero-extended. A long stretch of pseudo-random writes and pulses compares `irq` against the model every cycle, which exposes a request computed from stale enable or pending values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQC_ADDR_W = 8;
  localparam logic [IRQC_ADDR_W-1:0] IRQC_PEND_OFS = 8'h70;
  localparam logic [IRQC_ADDR_W-1:0] IRQC_ENAB_OFS = 8'h74;

  typedef struct packed {
    logic sel_pend;
    logic sel_enab;
    logic wr_pend;
    logic wr_enab;
  } irqc_sel_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = IRQC_ADDR_W,
  parameter logic [ADDR_W-1:0] PEND_OFS = IRQC_PEND_OFS,
  parameter logic [ADDR_W-1:0] ENAB_OFS = IRQC_ENAB_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output irqc_sel_t         sel
);
  always_comb begin
    sel.sel_pend = (addr == PEND_OFS);
    sel.sel_enab = (addr == ENAB_OFS);
    sel.wr_pend  = wr && sel.sel_pend;
    sel.wr_enab  = wr && sel.sel_enab;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel.wr_pend, sel.wr_enab})); // R8
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int unsigned NSRC    = 16,
  parameter int unsigned DMA_BIT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_wr,
  input  logic [NSRC-1:0] ack_data,
  input  logic [NSRC-1:0] src_set,
  input  logic            dma_set,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] status_d
);
  logic [NSRC-1:0] set_all;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    localparam bit IS_DMA = (i == DMA_BIT);
    logic keep;
    assign set_all[i]  = IS_DMA ? (src_set[i] | dma_set) : src_set[i];
    assign keep        = ack_wr ? ack_data[i] : 1'b1;
    // set has priority over a clearing write
    assign status_d[i] = set_all[i] | (status_q[i] & keep);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_wr && set_all == '0) |=> $stable(status_q)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((status_q & ~$past(ack_data) & ~$past(set_all)) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all != '0) |=> ((status_q & $past(set_all)) == $past(set_all))); // R4
endmodule

// File: rtl/irqc_req.sv
module irqc_req #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] mask_data,
  input  logic [NSRC-1:0] status_q,
  input  logic [NSRC-1:0] status_d,
  output logic [NSRC-1:0] mask_q,
  output logic            irq,
  output logic            unmask_evt
);
  logic [NSRC-1:0] mask_d;
  logic            exposed;

  assign mask_d  = mask_wr ? mask_data : mask_q;
  assign exposed = mask_wr && ((mask_data & ~mask_q & status_q) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      irq        <= 1'b0;
      unmask_evt <= 1'b0;
    end else begin
      mask_q     <= mask_d;
      irq        <= |(status_d & mask_d);
      unmask_evt <= exposed;
    end
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(status_q & mask_q)); // R6
  AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_evt |-> $past(mask_wr)); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q)); // R5
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC    = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = IRQC_ADDR_W,
  parameter int unsigned DMA_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_set,
  input  logic              dma_set,
  output logic              irq,
  output logic              unmask_evt
);
  localparam int unsigned PAD_W = DATA_W - NSRC;

  irqc_sel_t       sel;
  logic [NSRC-1:0] status_q, status_d, mask_q;

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .sel(sel)
  );

  irqc_status #(.NSRC(NSRC), .DMA_BIT(DMA_BIT)) u_stat (
    .clk(clk), .rst_n(rst_n), .ack_wr(sel.wr_pend),
    .ack_data(bus_wdata[NSRC-1:0]), .src_set(src_set), .dma_set(dma_set),
    .status_q(status_q), .status_d(status_d)
  );

  irqc_req #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .mask_wr(sel.wr_enab),
    .mask_data(bus_wdata[NSRC-1:0]), .status_q(status_q), .status_d(status_d),
    .mask_q(mask_q), .irq(irq), .unmask_evt(unmask_evt)
  );

  always_comb begin
    if (sel.sel_pend)      bus_rdata = {{PAD_W{1'b0}}, status_q};
    else if (sel.sel_enab) bus_rdata = {{PAD_W{1'b0}}, mask_q};
    else                   bus_rdata = '0;
  end
endmodule

// File: tb/irqc_ctrl_bench.sv
`timescale 1ns/1ps
module irqc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [15:0] src_set = 16'h0;
  logic        dma_set = 1'b0;
  logic        irq, unmask_evt;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;
  int m_stat = 0, m_mask = 0, m_irq = 0, m_evt = 0;

  always #2 clk = ~clk;

  irqc_ctrl u_irqc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_set(src_set),
    .dma_set(dma_set), .irq(irq), .unmask_evt(unmask_evt)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int ns, nm, ev;
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_irq = 0; m_evt = 0;
    end else begin
      ns = m_stat;
      nm = m_mask;
      ev = 0;
      if (bus_wr && bus_addr == 8'h70) ns = ns & int'(bus_wdata[15:0]);
      ns = ns | int'(src_set) | (dma_set ? 8 : 0);
      if (bus_wr && bus_addr == 8'h74) begin
        if ((int'(bus_wdata[15:0]) & ~m_mask & m_stat & 16'hffff) != 0) ev = 1;
        nm = int'(bus_wdata[15:0]);
      end
      m_stat = ns; m_mask = nm; m_evt = ev;
      m_irq = ((ns & nm) != 0) ? 1 : 0;
    end
  end

  function automatic int exp_rd(int a);
    if (a == 8'h70) return m_stat;
    if (a == 8'h74) return m_mask;
    return 0;
  endfunction

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (irq !== m_irq[0]) begin
        errors++;
        $display("FAIL %s irq actual=%0b expected=%0d t=%0t", cur_req, irq, m_irq, $time);
      end
      checks++;
      if (unmask_evt !== m_evt[0]) begin
        errors++;
        $display("FAIL %s unmask_evt actual=%0b expected=%0d t=%0t", cur_req, unmask_evt, m_evt, $time);
      end
      checks++;
      if (bus_rdata !== 32'(exp_rd(int'(bus_addr)))) begin
        errors++;
        $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t", cur_req, bus_addr,
                 bus_rdata, exp_rd(int'(bus_addr)), $time);
      end
    end
  end

  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [15:0] s, input bit dm);
    @(negedge clk); #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d; src_set = s; dma_set = dm;
  endtask

  task automatic rd(input logic [7:0] a);
    step(0, a, 32'h0, 16'h0, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    cur_req = "R1";
    repeat (3) rd(8'h70);
    rst_n = 1'b1;
    rd(8'h70); rd(8'h74); rd(8'h74);

    cur_req = "R2";
    step(0, 8'h70, 0, 16'h0101, 0);
    rd(8'h70); rd(8'h70); rd(8'h70);

    cur_req = "R9";
    step(0, 8'h70, 0, 16'h0000, 1);
    rd(8'h70); rd(8'h70);

    cur_req = "R3";
    step(1, 8'h70, 32'h0000_FFF7, 0, 0);
    rd(8'h70);
    step(1, 8'h70, 32'hFFFF_00FF, 0, 0);
    rd(8'h70);

    cur_req = "R5";
    step(1, 8'h74, 32'h0000_0001, 0, 0);
    rd(8'h74); rd(8'h74);
    cur_req = "R6";
    step(1, 8'h74, 32'h0000_0000, 0, 0);
    rd(8'h74);
    step(1, 8'h74, 32'h0000_0002, 16'h0002, 0);
    rd(8'h74); rd(8'h70);

    cur_req = "R7";
    step(0, 8'h70, 0, 16'h0010, 0);
    step(1, 8'h74, 32'h0000_0010, 0, 0);
    rd(8'h74);
    step(1, 8'h74, 32'h0000_0011, 0, 0);
    rd(8'h74);
    step(1, 8'h74, 32'h0000_0011, 0, 0);
    rd(8'h74);
    step(1, 8'h74, 32'h0000_0100, 0, 0);
    rd(8'h74);

    cur_req = "R4";
    step(1, 8'h70, 32'h0000_0000, 16'h0002, 0);
    rd(8'h70);
    step(1, 8'h70, 32'h0000_0000, 16'h0000, 1);
    rd(8'h70);

    cur_req = "R8";
    step(1, 8'h74, 32'hABCD_00F0, 0, 0);
    rd(8'h74);
    step(1, 8'h78, 32'hFFFF_FFFF, 0, 0);
    rd(8'h78); rd(8'h70); rd(8'h74);
    step(1, 8'h00, 32'h0000_0000, 0, 0);
    rd(8'h70); rd(8'h74);

    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[1] ? 8'h74 : 8'h70;
      step(lfsr[0] & lfsr[5], a, {lfsr, lfsr ^ 16'h5A3C},
           (lfsr[3:2] == 2'b00) ? (16'h1 << lfsr[11:8]) : 16'h0, lfsr[7] & lfsr[6]);
    end
    rd(8'h70);

    cur_req = "R1";
    @(negedge clk); #1;
    rst_n = 1'b0; bus_wr = 0; src_set = 0; dma_set = 0; bus_addr = 8'h70;
    rd(8'h70); rd(8'h74);
    rst_n = 1'b1;
    rd(8'h70);
    @(negedge clk); #1;
    finish_run();
  end
endmodule